// File: doc/BRIEF.md
# Key-Gated Indexed Configuration Port

This block is a host-visible configuration register file that sits on an 8-bit I/O bus and is reached through two adjacent addresses: an index port at the pair's base and a data port one address above it. A strap input picks which of two possible pair bases answers. Until the host writes an unlock key to the index port on two writes in a row, every register is hidden. A single lock key written to the index port hides them again.

While open, a write to the index port chooses a register. A later read or write at the data port then reaches that register. One global register holds a logical device number. That number chooses which of several per-device banks answers the bank indices. Each bank drives its own enable flag, 16-bit base address and interrupt-select value out to the device it configures. Two read-only 16-bit identifiers, a chip ID and a vendor ID, are also visible, each split into a high byte and a low byte.

Top module: `cfg_port_gate`

## Requirements
- R1: After reset the block is locked, the logical device number is 0, every device enable, base address and interrupt select is 0, and `io_rdata` reads 0xFF.
- R2: The port opens (`cfg_open_o` = 1 on the cycle after the second write) only after the unlock key (default 0x87) is written to the active index port on two successive writes to the active pair.
- R3: Between the two unlock-key writes, any other write to the active pair restarts the sequence, so a further single key write does not open the port. Writes to other addresses do not disturb the sequence.
- R4: While open, writing the lock key (default 0xAA) to the index port closes the port and leaves the index register unchanged. Any other value written there becomes the new index.
- R5: While locked, reads at any address return 0xFF, and data-port writes change no register or output.
- R6: Reads at any address other than the active pair (base selected by `pair_sel`: 0 gives 0x002E, 1 gives 0x004E) return 0xFF, and writes there are ignored, including key writes.
- R7: While open, a read of the index port returns the current index, and a read of the data port returns the register that index selects. The read result appears on `io_rdata` after the clock edge that samples `io_rd` and holds until the next read.
- R8: Index 0x07 holds the logical device number. Bank indices reach only the device whose number equals it, and that device's outputs alone change.
- R9: The bank indices are 0x30 for enable (bit 0 stored, read back as 0x00 or 0x01), 0x60 for base address bits 15:8, 0x61 for base bits 7:0, and 0x70 for interrupt select. They drive `dev_en_o[n]`, `dev_base_o[16n+:16]` and `dev_irq_o[8n+:8]`.
- R10: Indices 0x20/0x21 read the chip ID high/low bytes and 0x23/0x24 read the vendor ID high/low bytes (defaults 0x0A55 and 0x1B2C). Writes to these indices have no effect.
- R11: An unmapped index reads 0x00. With a logical device number at or above the device count, bank indices read 0x00 and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_sel | input | 1 | Strap choosing which port pair base is active |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cfg_open_o | output | 1 | High while configuration access is open |
| dev_en_o | output | NUM_DEV | Per-device enable |
| dev_base_o | output | 16*NUM_DEV | Per-device base address, device n in bits 16n+15:16n |
| dev_irq_o | output | 8*NUM_DEV | Per-device interrupt select, device n in bits 8n+7:8n |

## Verification
The bench targets the unlock sequence at its edges. It sends a key, then a stray data-port write, then a key, and a design that only counted key writes would open the port too early. It also sends key writes to the inactive pair, which must not count, and a lock key written while open, which must close the port without changing the index. Bank steering is checked by programming one device and reading another: a design that ignored the logical device number would show the values in every device's outputs. Out-of-range device numbers, unmapped indices and writes to the identifier bytes must read as zero or stay unchanged, and a design that aliased them would change outputs or report non-zero bytes. Random traffic biased toward key values, including strap flips, runs against a bench model of the whole port.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lk_state_t;

  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_CHIP_HI = 8'h20;
  localparam logic [7:0] IDX_CHIP_LO = 8'h21;
  localparam logic [7:0] IDX_VEND_HI = 8'h23;
  localparam logic [7:0] IDX_VEND_LO = 8'h24;
  localparam logic [7:0] IDX_DEV_EN  = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_IRQ     = 8'h70;

  localparam logic [7:0] BLANK_READ = 8'hFF;

  // True for indices that reach the selected device bank.
  function automatic logic is_bank_idx(input logic [7:0] idx);
    return (idx == IDX_DEV_EN) || (idx == IDX_BASE_HI) ||
           (idx == IDX_BASE_LO) || (idx == IDX_IRQ);
  endfunction

  // Read value of a global (non-bank) index.
  function automatic logic [7:0] global_read(input logic [7:0] idx,
                                             input logic [7:0] ldn,
                                             input logic [15:0] chip,
                                             input logic [15:0] vend);
    case (idx)
      IDX_LDN:     return ldn;
      IDX_CHIP_HI: return chip[15:8];
      IDX_CHIP_LO: return chip[7:0];
      IDX_VEND_HI: return vend[15:8];
      IDX_VEND_LO: return vend[7:0];
      default:     return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgp_seq.sv
module cfgp_seq
  import cfgp_pkg::*;
#(
  parameter logic [7:0] UNLOCK_KEY = 8'h87,
  parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_idx,
  input  logic       wr_pair,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic       lock_evt_o
);

  lk_state_t state_q, state_d;
  logic      key_w;

  assign key_w      = wr_idx && (wdata == UNLOCK_KEY);
  assign lock_evt_o = (state_q == LK_OPEN) && wr_idx && (wdata == LOCK_KEY);

  always_comb begin
    state_d = state_q;
    case (state_q)
      LK_CLOSED: if (key_w) state_d = LK_HALF;
      LK_HALF: begin
        if (key_w)        state_d = LK_OPEN;
        else if (wr_pair) state_d = LK_CLOSED;
      end
      LK_OPEN:   if (lock_evt_o) state_d = LK_CLOSED;
      default:   state_d = LK_CLOSED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LK_CLOSED;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == LK_OPEN);

endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic        en_o,
  output logic [15:0] base_o,
  output logic [7:0]  irq_o,
  output logic [7:0]  rd_val_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o   <= 1'b0;
      base_o <= 16'h0000;
      irq_o  <= 8'h00;
    end else if (wr_en) begin
      case (idx)
        IDX_DEV_EN:  en_o         <= wdata[0];
        IDX_BASE_HI: base_o[15:8] <= wdata;
        IDX_BASE_LO: base_o[7:0]  <= wdata;
        IDX_IRQ:     irq_o        <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_DEV_EN:  rd_val_o = {7'd0, en_o};
      IDX_BASE_HI: rd_val_o = base_o[15:8];
      IDX_BASE_LO: rd_val_o = base_o[7:0];
      IDX_IRQ:     rd_val_o = irq_o;
      default:     rd_val_o = 8'h00;
    endcase
  end

endmodule

// File: rtl/cfg_port_gate.sv
module cfg_port_gate
  import cfgp_pkg::*;
#(
  parameter int          NUM_DEV    = 4,
  parameter logic [15:0] PAIR0_BASE = 16'h002E,
  parameter logic [15:0] PAIR1_BASE = 16'h004E,
  parameter logic [7:0]  UNLOCK_KEY = 8'h87,
  parameter logic [7:0]  LOCK_KEY   = 8'hAA,
  parameter logic [15:0] CHIP_ID    = 16'h0A55,
  parameter logic [15:0] VENDOR_ID  = 16'h1B2C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pair_sel,
  input  logic [15:0]           io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic                  cfg_open_o,
  output logic [NUM_DEV-1:0]    dev_en_o,
  output logic [16*NUM_DEV-1:0] dev_base_o,
  output logic [8*NUM_DEV-1:0]  dev_irq_o
);

  localparam int BASE_W = 16;
  localparam int IRQ_W  = 8;

  // Named decode events, also used by the checker.
  logic [15:0] act_base;
  logic        hit_idx, hit_dat, pair_hit;
  logic        wr_idx, wr_dat, cfg_wr, lock_evt;
  logic        ldn_valid, bank_wr;

  logic [7:0]  idx_q, ldn_q;
  logic [7:0]  bank_rd [NUM_DEV];
  logic [7:0]  bank_sel_val;
  logic [7:0]  data_val;

  assign act_base = pair_sel ? PAIR1_BASE : PAIR0_BASE;
  assign hit_idx  = (io_addr == act_base);
  assign hit_dat  = (io_addr == act_base + 16'd1);
  assign pair_hit = hit_idx || hit_dat;
  assign wr_idx   = io_wr && hit_idx;
  assign wr_dat   = io_wr && hit_dat;

  cfgp_seq #(
    .UNLOCK_KEY(UNLOCK_KEY),
    .LOCK_KEY  (LOCK_KEY)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_idx    (wr_idx),
    .wr_pair   (io_wr && pair_hit),
    .wdata     (io_wdata),
    .open_o    (cfg_open_o),
    .lock_evt_o(lock_evt)
  );

  assign cfg_wr    = cfg_open_o && wr_dat;
  assign ldn_valid = ({24'd0, ldn_q} < NUM_DEV);
  assign bank_wr   = cfg_wr && is_bank_idx(idx_q) && ldn_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (cfg_open_o && wr_idx && !lock_evt) idx_q <= io_wdata;
      if (cfg_wr && (idx_q == IDX_LDN))      ldn_q <= io_wdata;
    end
  end

  for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_bank
    cfgp_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr && (ldn_q == 8'(gi))),
      .idx     (idx_q),
      .wdata   (io_wdata),
      .en_o    (dev_en_o[gi]),
      .base_o  (dev_base_o[gi*BASE_W +: BASE_W]),
      .irq_o   (dev_irq_o[gi*IRQ_W +: IRQ_W]),
      .rd_val_o(bank_rd[gi])
    );
  end

  always_comb begin
    bank_sel_val = 8'h00;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (ldn_q == 8'(i)) bank_sel_val = bank_rd[i];
    end
  end

  assign data_val = is_bank_idx(idx_q) ? bank_sel_val
                                       : global_read(idx_q, ldn_q, CHIP_ID, VENDOR_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rdata <= BLANK_READ;
    end else if (io_rd) begin
      if (!(cfg_open_o && pair_hit)) io_rdata <= BLANK_READ;
      else if (hit_idx)              io_rdata <= idx_q;
      else                           io_rdata <= data_val;
    end
  end

endmodule

// File: rtl/cfgp_gate_chk.sv
module cfgp_gate_chk #(
  parameter int         NUM_DEV    = 4,
  parameter logic [7:0] UNLOCK_KEY = 8'h87,
  parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  io_wr,
  input logic                  io_rd,
  input logic [7:0]            io_wdata,
  input logic [7:0]            io_rdata,
  input logic                  cfg_open,
  input logic                  hit_idx,
  input logic                  pair_hit,
  input logic [NUM_DEV-1:0]    dev_en,
  input logic [16*NUM_DEV-1:0] dev_base
);

  // R2
  unlock_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && hit_idx && (io_wdata == UNLOCK_KEY)));

  // R3
  no_early_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && !(io_wr && hit_idx && (io_wdata == UNLOCK_KEY))) |=> !cfg_open);

  // R4
  lock_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && hit_idx && (io_wdata == LOCK_KEY)) |=> !cfg_open);

  // R5
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !cfg_open) |=> (io_rdata == 8'hFF));

  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(dev_en) && $stable(dev_base)));

  // R6
  foreign_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !pair_hit) |=> (io_rdata == 8'hFF));

endmodule

bind cfg_port_gate cfgp_gate_chk #(
  .NUM_DEV   (NUM_DEV),
  .UNLOCK_KEY(UNLOCK_KEY),
  .LOCK_KEY  (LOCK_KEY)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_wr    (io_wr),
  .io_rd    (io_rd),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .cfg_open (cfg_open_o),
  .hit_idx  (hit_idx),
  .pair_hit (pair_hit),
  .dev_en   (dev_en_o),
  .dev_base (dev_base_o)
);

// File: tb/cfg_port_gate_tb.sv
module cfg_port_gate_tb;

  localparam int          ND   = 4;
  localparam logic [15:0] P0   = 16'h002E;
  localparam logic [15:0] P1   = 16'h004E;
  localparam logic [7:0]  UNL  = 8'h87;
  localparam logic [7:0]  LCK  = 8'hAA;
  localparam logic [15:0] CHIP = 16'h0A55;
  localparam logic [15:0] VEND = 16'h1B2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pair_sel = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h0;
  logic [7:0] io_rdata;
  logic cfg_open_o;
  logic [ND-1:0] dev_en_o;
  logic [16*ND-1:0] dev_base_o;
  logic [8*ND-1:0] dev_irq_o;

  always #5 clk = ~clk;

  cfg_port_gate u_dut (
    .clk(clk), .rst_n(rst_n), .pair_sel(pair_sel), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_open_o(cfg_open_o), .dev_en_o(dev_en_o), .dev_base_o(dev_base_o),
    .dev_irq_o(dev_irq_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // Bench model: 0 closed, 1 one key seen, 2 open
  int m_st = 0;
  logic [7:0] m_idx = 0, m_ldn = 0;
  logic m_en [ND];
  logic [15:0] m_base [ND];
  logic [7:0] m_irq [ND];

  function automatic logic [15:0] act();
    return pair_sel ? P1 : P0;
  endfunction

  function automatic logic [7:0] reg_val(input logic [7:0] i);
    bit ok = (m_ldn < ND);
    case (i)
      8'h07: return m_ldn;
      8'h20: return CHIP[15:8];
      8'h21: return CHIP[7:0];
      8'h23: return VEND[15:8];
      8'h24: return VEND[7:0];
      8'h30: return ok ? {7'd0, m_en[m_ldn[1:0]]} : 8'h00;
      8'h60: return ok ? m_base[m_ldn[1:0]][15:8] : 8'h00;
      8'h61: return ok ? m_base[m_ldn[1:0]][7:0] : 8'h00;
      8'h70: return ok ? m_irq[m_ldn[1:0]] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    if (m_st != 2) return 8'hFF;
    if (a == act()) return m_idx;
    if (a == act() + 16'd1) return reg_val(m_idx);
    return 8'hFF;
  endfunction

  task automatic m_write(input logic [15:0] a, input logic [7:0] d);
    if (a == act()) begin
      case (m_st)
        0: if (d == UNL) m_st = 1;
        1: m_st = (d == UNL) ? 2 : 0;
        default: if (d == LCK) m_st = 0; else m_idx = d;
      endcase
    end else if (a == act() + 16'd1) begin
      if (m_st == 1) m_st = 0;
      else if (m_st == 2) begin
        if (m_idx == 8'h07) m_ldn = d;
        else if (m_ldn < ND) begin
          case (m_idx)
            8'h30: m_en[m_ldn[1:0]] = d[0];
            8'h60: m_base[m_ldn[1:0]][15:8] = d;
            8'h61: m_base[m_ldn[1:0]][7:0] = d;
            8'h70: m_irq[m_ldn[1:0]] = d;
            default: ;
          endcase
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    m_write(a, d);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    v = io_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a);
    logic [7:0] v, e;
    e = exp_read(a);
    rd(a, v);
    chk(req, {56'd0, v}, {56'd0, e});
  endtask

  task automatic outs_chk(input string req);
    for (int i = 0; i < ND; i++) begin
      chk(req, {63'd0, dev_en_o[i]}, {63'd0, m_en[i]});
      chk(req, {48'd0, dev_base_o[i*16 +: 16]}, {48'd0, m_base[i]});
      chk(req, {56'd0, dev_irq_o[i*8 +: 8]}, {56'd0, m_irq[i]});
    end
  endtask

  task automatic unlock();
    wr(act(), UNL);
    wr(act(), UNL);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < ND; i++) begin
      m_en[i] = 0; m_base[i] = 0; m_irq[i] = 0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", {56'd0, io_rdata}, 64'hFF);
    chk("R1 open", {63'd0, cfg_open_o}, 0);
    outs_chk("R1 outputs");

    // R5 locked: read FF, data write ignored
    rd_chk("R5 locked read", P0 + 16'd1);
    wr(P0 + 16'd1, 8'h5A);
    outs_chk("R5 locked write");

    // R3 stray data write between keys restarts
    wr(P0, UNL); wr(P0 + 16'd1, 8'h00); wr(P0, UNL);
    chk("R3 stray data write", {63'd0, cfg_open_o}, 0);
    wr(P0, 8'h33); wr(P0, UNL);
    chk("R3 stray index write", {63'd0, cfg_open_o}, 0);
    // R3 writes elsewhere do not disturb
    wr(16'h0080, 8'h11); wr(P0, UNL);
    chk("R3 other address", {63'd0, cfg_open_o}, 1);
    wr(P0, LCK);

    // R6 keys at the inactive pair do nothing
    wr(P1, UNL); wr(P1, UNL);
    chk("R6 inactive keys", {63'd0, cfg_open_o}, 0);

    // R2 open
    unlock();
    chk("R2 open", {63'd0, cfg_open_o}, 1);
    // R1 ldn reset
    wr(P0, 8'h07); rd_chk("R1 ldn", P0 + 16'd1);
    // R7 index readback
    rd_chk("R7 index", P0);
    // R6 inactive read while open
    rd_chk("R6 inactive read", P1 + 16'd1);

    // R10 ids read-only
    wr(P0, 8'h20); rd_chk("R10 chip hi", P0 + 16'd1);
    wr(P0 + 16'd1, 8'h00); rd_chk("R10 chip hi after write", P0 + 16'd1);
    wr(P0, 8'h21); rd_chk("R10 chip lo", P0 + 16'd1);
    wr(P0, 8'h23); rd_chk("R10 vend hi", P0 + 16'd1);
    wr(P0, 8'h24); rd_chk("R10 vend lo", P0 + 16'd1);

    // R8 R9 program device 2
    wr(P0, 8'h07); wr(P0 + 16'd1, 8'd2);
    wr(P0, 8'h60); wr(P0 + 16'd1, 8'h03);
    wr(P0, 8'h61); wr(P0 + 16'd1, 8'hF8);
    wr(P0, 8'h70); wr(P0 + 16'd1, 8'h04);
    wr(P0, 8'h30); wr(P0 + 16'd1, 8'hFF);
    rd_chk("R9 enable readback", P0 + 16'd1);
    chk("R8 only dev2 enabled", {60'd0, dev_en_o}, 64'h4);
    outs_chk("R9 dev outputs");
    wr(P0, 8'h07); wr(P0 + 16'd1, 8'd1);
    wr(P0, 8'h61); rd_chk("R8 other bank", P0 + 16'd1);

    // R11 unmapped and out-of-range device
    wr(P0, 8'h55); rd_chk("R11 unmapped", P0 + 16'd1);
    wr(P0, 8'h07); wr(P0 + 16'd1, 8'd9);
    wr(P0, 8'h70); wr(P0 + 16'd1, 8'h77);
    rd_chk("R11 ldn out of range", P0 + 16'd1);
    outs_chk("R11 dropped write");

    // R4 lock keeps index
    wr(P0, LCK);
    chk("R4 closed", {63'd0, cfg_open_o}, 0);
    rd_chk("R4 locked read", P0);
    unlock();
    rd_chk("R4 index kept", P0);

    // Random traffic
    for (int n = 0; n < 1500; n++) begin
      int r = $urandom_range(0, 99);
      logic [15:0] a;
      logic [7:0] d;
      int ar = $urandom_range(0, 9);
      if (ar < 4) a = act();
      else if (ar < 8) a = act() + 16'd1;
      else if (ar < 9) a = (pair_sel ? P0 : P1) + 16'($urandom_range(0, 1));
      else a = 16'($urandom_range(0, 255));
      case ($urandom_range(0, 9))
        0, 1, 2: d = UNL;
        3:       d = LCK;
        4, 5:    d = 8'h07;
        6:       d = 8'(8'h60 + $urandom_range(0, 1));
        7:       d = ($urandom_range(0, 1) != 0) ? 8'h30 : 8'h70;
        8:       d = 8'($urandom_range(0, 5));
        default: d = 8'($urandom);
      endcase
      if (r < 3) begin
        @(negedge clk);
        pair_sel = ~pair_sel;
      end else if (r < 55) wr(a, d);
      else rd_chk("R7 random read", a);
      if (n % 100 == 99) begin
        outs_chk("R8 random outputs");
        chk("R2 random open", {63'd0, cfg_open_o}, {63'd0, m_st == 2});
      end
    end

    finish_run();
  end

endmodule